// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Output Pipelining

This block is a true dual-port memory with two independent ports, A and B. Each port has its own address, write data, read data, write strobe, a pair of chip selects, an output enable and an output-mode input. Either port can read or write any word in the same cycle as the other port. All controls except the output enable are sampled on the rising edge of a shared clock. There are no tristate pins. Each port instead has a drive-enable output, and its read data reads zero whenever that enable is low.

The port's mode input picks one of two read paths. In flow-through mode, the word at the sampled address is presented during the cycle that follows the sampling edge. In pipelined mode, the word passes through one more output register and appears one cycle later. The drive-enable tracks the same latency. Deselecting the port, or sampling a write, removes the drive after the matching number of edges. A pipelined port that comes back from deselection needs one selected cycle before it drives again. The output enable acts at once in either mode.

Top module: `dpram_sync`

## Requirements
- R1: A port counts as selected only when its active-low select is 0 and its active-high select is 1. Any other combination deselects it: it stores nothing and does not drive.
- R2: A selected port with its write strobe low stores its write data at its address on that edge. The two ports can store to different addresses on the same edge.
- R3: In flow-through mode (mode input 0), a selected read sampled on an edge makes the drive-enable 1 and the read data equal to the addressed word during the following cycle, provided the output enable is low.
- R4: In pipelined mode (mode input 1), the read data and the drive-enable for a read appear one clock cycle later than in flow-through mode.
- R5: Deselection sampled on an edge clears the drive-enable after that edge in flow-through mode. In pipelined mode it clears the drive-enable after the next edge.
- R6: In pipelined mode, a port returning from deselection drives only after one selected read cycle has passed through the output register.
- R7: The active-low output enable is asynchronous. When it is 1, the drive-enable is 0 and the read data is 0 in either mode, with no clock edge needed.
- R8: A sampled write produces no drive in the cycle that would carry its read result: the next cycle in flow-through mode, the cycle after that in pipelined mode.
- R9: When one port reads an address on the same edge that the other port writes it, the reading port returns the word stored before that write.
- R10: While reset (active low) is held, both drive-enables are 0, both read data outputs are 0 and the pipeline registers are cleared.
- R11: A write strobe on a deselected port leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; rising edge samples all synchronous inputs |
| rst_n | input | 1 | Active-low reset of control and pipeline registers |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A write strobe, 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A mode, 0 = flow-through, 1 = pipelined |
| a_rdata | output | DATA_W | Port A read data, 0 when not driving |
| a_drive | output | 1 | Port A drive-enable, stands in for the tristate control |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B write strobe, 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B mode, 0 = flow-through, 1 = pipelined |
| b_rdata | output | DATA_W | Port B read data, 0 when not driving |
| b_drive | output | 1 | Port B drive-enable |

## Verification
The assertions check the drive-enable timing on every cycle, and they cover both modes. They check flow-through drive after a selected read, absence of drive after a write or a deselection, the extra pipelined cycle on reselection, the immediate effect of the output enable and the quiet state under reset. Only the bench's scenarios can show that the data itself is right. That covers stored words coming back on either port, ignored writes from deselected ports, the one-cycle shift in pipelined mode and a read that collides with a write from the other port returning the old word.

// File: rtl/dpram_sync.sv
`timescale 1ns/1ps
module dpram_sync #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_sel_n,
  input  logic              a_sel,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_drive,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_sel_n,
  input  logic              b_sel,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic a_hit, b_hit;
  assign a_hit = !a_sel_n && a_sel;
  assign b_hit = !b_sel_n && b_sel;

  always_ff @(posedge clk) begin
    if (a_hit && !a_wr_n) mem[a_addr] <= a_wdata;
    if (b_hit && !b_wr_n) mem[b_addr] <= b_wdata;
  end

  logic [DATA_W-1:0] a_rd_q, b_rd_q;
  always_ff @(posedge clk) begin
    a_rd_q <= mem[a_addr];
    b_rd_q <= mem[b_addr];
  end

  logic              a_en_q, a_en_p, a_mode_q;
  logic              b_en_q, b_en_p, b_mode_q;
  logic [DATA_W-1:0] a_out_q, b_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_en_q   <= 1'b0;
      a_en_p   <= 1'b0;
      a_mode_q <= 1'b0;
      a_out_q  <= '0;
      b_en_q   <= 1'b0;
      b_en_p   <= 1'b0;
      b_mode_q <= 1'b0;
      b_out_q  <= '0;
    end else begin
      a_en_q   <= a_hit && a_wr_n;
      a_en_p   <= a_en_q;
      a_mode_q <= a_pipe;
      a_out_q  <= a_rd_q;
      b_en_q   <= b_hit && b_wr_n;
      b_en_p   <= b_en_q;
      b_mode_q <= b_pipe;
      b_out_q  <= b_rd_q;
    end
  end

  assign a_drive = !a_oe_n && (a_mode_q ? a_en_p : a_en_q);
  assign b_drive = !b_oe_n && (b_mode_q ? b_en_p : b_en_q);
  assign a_rdata = a_drive ? (a_mode_q ? a_out_q : a_rd_q) : '0;
  assign b_rdata = b_drive ? (b_mode_q ? b_out_q : b_rd_q) : '0;
endmodule

module dpram_sync_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic              a_sel_n,
  input logic              a_sel,
  input logic              a_wr_n,
  input logic              a_oe_n,
  input logic              a_pipe,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_drive,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic              b_sel_n,
  input logic              b_sel,
  input logic              b_wr_n,
  input logic              b_oe_n,
  input logic              b_pipe,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_drive
);
  assert_ft_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pipe && !a_sel_n && a_sel && a_wr_n) |=> (a_drive == !a_oe_n));
  assert_ft_read_drive_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_pipe && !b_sel_n && b_sel && b_wr_n) |=> (b_drive == !b_oe_n));
  assert_ft_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pipe && (a_sel_n || !a_sel)) |=> !a_drive);
  assert_pipe_reselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_pipe && (a_sel_n || !a_sel)) ##1 a_pipe) |=> !a_drive);
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n |-> (!a_drive && a_rdata == '0));
  assert_oe_gate_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe_n |-> (!b_drive && b_rdata == '0));
  assert_ft_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pipe && !a_sel_n && a_sel && !a_wr_n) |=> !a_drive);
  assert_pipe_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_pipe && !b_sel_n && b_sel && !b_wr_n) ##1 b_pipe) |=> !b_drive);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> (!a_drive && !b_drive && a_rdata == '0 && b_rdata == '0));
endmodule

bind dpram_sync dpram_sync_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpram_sync_bench.sv
`timescale 1ns/1ps
module dpram_sync_bench;
  localparam int AW = 11;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic a_sel_n = 1'b1, a_sel = 1'b0, a_wr_n = 1'b1, a_oe_n = 1'b0, a_pipe = 1'b0;
  logic b_sel_n = 1'b1, b_sel = 1'b0, b_wr_n = 1'b1, b_oe_n = 1'b0, b_pipe = 1'b0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_drive, b_drive;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpram_sync #(.ADDR_W(AW), .DATA_W(DW)) u_dpram_sync (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_sel_n(a_sel_n), .a_sel(a_sel),
    .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_pipe(a_pipe),
    .a_rdata(a_rdata), .a_drive(a_drive),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_sel_n(b_sel_n), .b_sel(b_sel),
    .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_pipe(b_pipe),
    .b_rdata(b_rdata), .b_drive(b_drive)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pa(input logic sn, input logic s, input logic wn, input logic pm,
                    input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_sel_n = sn; a_sel = s; a_wr_n = wn; a_pipe = pm; a_addr = ad; a_wdata = d;
  endtask

  task automatic pb(input logic sn, input logic s, input logic wn, input logic pm,
                    input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_sel_n = sn; b_sel = s; b_wr_n = wn; b_pipe = pm; b_addr = ad; b_wdata = d;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R10 a_drive", a_drive, 0);
    chk("R10 b_drive", b_drive, 0);
    chk("R10 a_rdata", a_rdata, 0);
    chk("R10 b_rdata", b_rdata, 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_write_ignore_read();
    pa(0, 1, 0, 0, 11'd5, 9'h1A5); pb(0, 1, 0, 0, 11'd6, 9'h0F3); tick();
    pa(0, 1, 0, 0, 11'd9, 9'h100); pb(1, 0, 1, 0, 11'd0, 9'h000); tick();
    pa(1, 1, 0, 0, 11'd5, 9'h000); pb(0, 0, 0, 0, 11'd6, 9'h000); tick();
    pa(0, 1, 1, 0, 11'd5, 9'h000); pb(0, 1, 1, 0, 11'd6, 9'h000); tick();
    chk("R3 a_drive ft read", a_drive, 1);
    chk("R2 R11 a word 5", a_rdata, 9'h1A5);
    chk("R3 b_drive ft read", b_drive, 1);
    chk("R2 R1 R11 b word 6", b_rdata, 9'h0F3);
    pb(1, 0, 1, 0, 11'd0, 9'h000);
  endtask

  task automatic t_ft_write_deselect();
    pa(0, 1, 0, 0, 11'd7, 9'h0AA); tick();
    chk("R8 ft no drive after write", a_drive, 0);
    pa(0, 1, 1, 0, 11'd7, 9'h000); tick();
    chk("R3 ft word 7", a_rdata, 9'h0AA);
    pa(0, 0, 1, 0, 11'd7, 9'h000); tick();
    chk("R5 ft deselect sel low", a_drive, 0);
    pa(1, 1, 1, 0, 11'd7, 9'h000); tick();
    chk("R1 ft deselect sel_n high", a_drive, 0);
  endtask

  task automatic t_ft_oe();
    pa(0, 1, 1, 0, 11'd5, 9'h000); tick();
    chk("R3 ft drive before oe", a_drive, 1);
    a_oe_n = 1'b1; #1;
    chk("R7 ft oe off drive", a_drive, 0);
    chk("R7 ft oe off data", a_rdata, 0);
    a_oe_n = 1'b0; #1;
    chk("R7 ft oe back", a_rdata, 9'h1A5);
  endtask

  task automatic t_pipe_read();
    pa(1, 0, 1, 1, 11'd0, 9'h000); tick(); tick();
    pa(0, 1, 1, 1, 11'd5, 9'h000); tick();
    chk("R4 pipe no drive yet", a_drive, 0);
    pa(0, 1, 1, 1, 11'd9, 9'h000); tick();
    chk("R4 pipe drive", a_drive, 1);
    chk("R4 pipe word 5", a_rdata, 9'h1A5);
    pa(0, 1, 1, 1, 11'd7, 9'h000); tick();
    chk("R4 pipe word 9", a_rdata, 9'h100);
  endtask

  task automatic t_pipe_deselect_reselect();
    pa(1, 0, 1, 1, 11'd0, 9'h000); tick();
    chk("R5 pipe still drives", a_drive, 1);
    chk("R5 pipe word 7", a_rdata, 9'h0AA);
    tick();
    chk("R5 pipe deselect off", a_drive, 0);
    pa(0, 1, 1, 1, 11'd6, 9'h000); tick();
    chk("R6 pipe reselect wait", a_drive, 0);
    tick();
    chk("R6 pipe reselect drive", a_drive, 1);
    chk("R6 pipe word 6", a_rdata, 9'h0F3);
    a_oe_n = 1'b1; #1;
    chk("R7 pipe oe off", a_drive, 0);
    a_oe_n = 1'b0; #1;
    chk("R7 pipe oe back", a_drive, 1);
  endtask

  task automatic t_pipe_write();
    pa(0, 1, 0, 1, 11'd8, 9'h033); tick();
    chk("R8 pipe prior read drives", a_rdata, 9'h0F3);
    pa(1, 0, 1, 1, 11'd0, 9'h000); tick();
    chk("R8 pipe no drive for write", a_drive, 0);
    pa(1, 0, 1, 0, 11'd0, 9'h000);
    pb(0, 1, 1, 0, 11'd8, 9'h000); tick();
    chk("R2 pipe write stored", b_rdata, 9'h033);
  endtask

  task automatic t_cross();
    pa(0, 1, 0, 0, 11'd9, 9'h055); pb(0, 1, 1, 0, 11'd9, 9'h000); tick();
    chk("R9 old word on collision", b_rdata, 9'h100);
    pa(1, 0, 1, 0, 11'd0, 9'h000); tick();
    chk("R9 new word after", b_rdata, 9'h055);
    pb(1, 0, 1, 0, 11'd0, 9'h000); tick();
  endtask

  initial begin
    t_reset();
    t_write_ignore_read();
    t_ft_write_deselect();
    t_ft_oe();
    t_pipe_read();
    t_pipe_deselect_reselect();
    t_pipe_write();
    t_cross();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule